// File: doc/BRIEF.md
# Timed Sample Capture Engine

This block takes samples from a converter at a fixed rate and puts them into on-chip memory with no processor involvement. A start pulse goes to the converter every P clock cycles, counted in hardware. As an alternative, the rising edge of an external trigger input can supply the start pulse. When the converter reports that a conversion is done, the result is stored at the next free buffer location. A free-running cycle counter supplies a timestamp for each stored sample, taken when the trigger fired. The processor receives one interrupt per full buffer. It reads the samples through a memory read port and then releases the interrupt, which makes the buffer ready for the next batch.

Software programs the engine through four small registers: the sample period, the index of the last buffer entry, a control word and a status word. The period can be rewritten while capture is running. The new period is used from the next counter wrap onward, so the interval already in progress is never cut short.

Top module: `sample_capture`

## Requirements
- R1: After reset, irq and conv_start are low, the status register (address 3) reads 0, and the period register (address 0) reads 1.
- R2: When enable (control register at address 2, bit 0) is set and bit 1 is clear, conv_start is a one-cycle pulse every P cycles, where P is the period register value. A period value of 0 is treated as 1.
- R3: A new period written while capture runs does not change the interval in progress. The intervals after the next counter wrap use the new value.
- R4: When control bit 1 is set, each rising edge of ext_trig raises conv_start in the cycle after the edge is sampled. A level held high produces one start, and period-counter wraps produce no start.
- R5: Each conv_done that arrives while a conversion is outstanding stores a word at the next buffer index. Bits 31:16 of the word hold the timestamp, bits 15:12 are zero and bits 11:0 hold conv_data. The timestamp is the value of a counter that is cleared by reset and advances by one each cycle, taken in the cycle the trigger fired.
- R6: irq rises on the clock edge that stores sample N, where N = 1 + the last-index register (address 1). N can be anything from 1 to DEPTH.
- R7: A trigger that arrives while a conversion is outstanding produces no conv_start and increments the overrun count in status bits 15:8. The count saturates at its maximum. Writing 1 to status bit 1 clears it.
- R8: While irq is high, completed samples are discarded, the buffer contents do not change, and the drop flag (status bit 1) is set.
- R9: Writing 1 to status bit 0 clears irq and the drop flag and returns the write index to 0. Status bit 0 reads back irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_trig | input | 1 | External trigger level, synchronous to clk |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| buf_raddr | input | ADDR_W | Buffer read index |
| buf_rdata | output | 32 | Buffer word, one cycle after buf_raddr |
| irq | output | 1 | Buffer-full interrupt |

## Verification
The bench builds the engine with DEPTH = 16. At that size every buffer length from 1 to 16 can be swept in a single run. Each length is filled, pushed into the dropped-sample state and released, and every stored word is compared against timestamps and data values computed in the bench. A bench converter model with an adjustable latency is used for three more checks: period intervals from 3 to 10 cycles, a period rewrite in the middle of an interval, and external edges that arrive while a conversion is still outstanding.

// File: rtl/sc_pkg.sv
// Shared constants and types for the sample capture engine.
// Assumes the buffer word layout is fixed at 32 bits: timestamp high, sample low.
package sc_pkg;
    localparam int SMP_W  = 12;
    localparam int TS_W   = 16;
    localparam int WORD_W = 32;
    localparam int PAD_W  = WORD_W - TS_W - SMP_W;

    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_LAST   = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [SMP_W-1:0] smp;
    } capture_t;
endpackage

// File: rtl/sc_rate_timer.sv
// Sample-rate down-counter and free-running timestamp counter.
// Assumes the period input may change at any time; it is only taken at a wrap.
module sc_rate_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PERIOD_W-1:0]     period,
    output logic                    tick,
    output logic [sc_pkg::TS_W-1:0] ts
);
    logic [PERIOD_W-1:0] eff_period;
    logic [PERIOD_W-1:0] cnt;

    // Clamp a zero period to one cycle.
    always_comb eff_period = (period == '0) ? PERIOD_W'(1) : period;

    assign tick = en && (cnt == '0);

    // Count down; reload from the period register only at a wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!en || tick) cnt <= eff_period - PERIOD_W'(1);
        else                  cnt <= cnt - PERIOD_W'(1);
    end

    // Free-running timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + sc_pkg::TS_W'(1);
    end

    // R3
    // R2
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != '0) |=> (!en || cnt == $past(cnt) - PERIOD_W'(1)));
endmodule

// File: rtl/sc_trig_ctrl.sv
// Trigger selection, converter handshake, overrun counting and timestamp hold.
// Assumes ext_in is already synchronous to clk and that conv_done is a one-cycle pulse.
module sc_trig_ctrl #(
    parameter int OVR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     src_ext,
    input  logic                     ext_in,
    input  logic                     tick,
    input  logic [sc_pkg::TS_W-1:0]  ts,
    input  logic                     conv_done,
    input  logic [sc_pkg::SMP_W-1:0] conv_data,
    input  logic                     ovr_clr,
    output logic                     conv_start,
    output logic [OVR_W-1:0]         ovr_cnt,
    output logic                     cap_valid,
    output sc_pkg::capture_t         cap
);
    logic                    ext_q;
    logic                    trig;
    logic                    busy;
    logic [sc_pkg::TS_W-1:0] ts_hold;

    // Pick the trigger source.
    always_comb trig = en && (src_ext ? (ext_in && !ext_q) : tick);

    // Remember the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_in;
    end

    // Issue starts, track the outstanding conversion and latch its timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            busy       <= 1'b0;
            ts_hold    <= '0;
        end else begin
            conv_start <= trig && !busy;
            if (trig && !busy) begin
                busy    <= 1'b1;
                ts_hold <= ts;
            end else if (conv_done) begin
                busy <= 1'b0;
            end
        end
    end

    // Saturating count of triggers lost to a busy converter.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr)               ovr_cnt <= '0;
        else if (trig && busy && !(&ovr_cnt)) ovr_cnt <= ovr_cnt + OVR_W'(1);
    end

    assign cap_valid = conv_done && busy;
    assign cap       = '{ts: ts_hold, smp: conv_data};

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R7
    overrun_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> !conv_start);
endmodule

// File: rtl/sc_cap_buffer.sv
// Sample RAM with write index, full interrupt and drop flag.
// Assumes last < DEPTH; a clear in the same cycle as a completion loses that sample.
module sc_cap_buffer #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  sc_pkg::capture_t          wr_cap,
    input  logic [ADDR_W-1:0]         last,
    input  logic                      clr,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [sc_pkg::WORD_W-1:0] rdata,
    output logic                      irq,
    output logic                      drop
);
    logic [sc_pkg::WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0]         wptr;
    logic                      wr_ok;

    assign wr_ok = wr_valid && !irq && !clr;

    // Store accepted samples in the buffer word layout.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= {wr_cap.ts, {sc_pkg::PAD_W{1'b0}}, wr_cap.smp};
    end

    // Registered read port.
    always_ff @(posedge clk) rdata <= mem[raddr];

    // Advance the write index, raise irq on the last entry, flag drops.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            irq  <= 1'b0;
            drop <= 1'b0;
        end else begin
            if (wr_ok) begin
                wptr <= wptr + ADDR_W'(1);
                if (wptr == last) irq <= 1'b1;
            end
            if (wr_valid && irq) drop <= 1'b1;
        end
    end

    // R6
    irq_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_valid));
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && wr_valid && !clr) |=> ($stable(wptr) && drop));
endmodule

// File: rtl/sample_capture.sv
// Top of the sample capture engine: register file plus timer, trigger and buffer.
// Assumes single-cycle register writes and combinational register reads.
module sample_capture #(
    parameter int DEPTH    = 256,
    parameter int PERIOD_W = 16,
    parameter int OVR_W    = 8,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     ext_trig,
    output logic                     conv_start,
    input  logic                     conv_done,
    input  logic [sc_pkg::SMP_W-1:0] conv_data,
    input  logic [ADDR_W-1:0]        buf_raddr,
    output logic [31:0]              buf_rdata,
    output logic                     irq
);
    import sc_pkg::*;

    logic [PERIOD_W-1:0] period_r;
    logic [ADDR_W-1:0]   last_r;
    logic                en_r, ext_sel_r;
    logic                tick, cap_valid, drop, buf_clr, ovr_clr;
    logic [TS_W-1:0]     ts;
    logic [OVR_W-1:0]    ovr_cnt;
    capture_t            cap;
    reg_sel_e            sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign buf_clr = reg_we && sel == REG_STAT && reg_wdata[0];
    assign ovr_clr = reg_we && sel == REG_STAT && reg_wdata[1];

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_r  <= PERIOD_W'(1);
            last_r    <= '0;
            en_r      <= 1'b0;
            ext_sel_r <= 1'b0;
        end else if (reg_we) begin
            case (sel)
                REG_PERIOD: period_r <= reg_wdata[PERIOD_W-1:0];
                REG_LAST:   last_r   <= reg_wdata[ADDR_W-1:0];
                REG_CTRL:   {ext_sel_r, en_r} <= reg_wdata[1:0];
                default:    ;
            endcase
        end
    end

    // Register read mux.
    always_comb begin
        case (sel)
            REG_PERIOD: reg_rdata = 32'(period_r);
            REG_LAST:   reg_rdata = 32'(last_r);
            REG_CTRL:   reg_rdata = {30'b0, ext_sel_r, en_r};
            default:    reg_rdata = (32'(ovr_cnt) << 8) | {30'b0, drop, irq};
        endcase
    end

    sc_rate_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en_r), .period(period_r),
        .tick(tick), .ts(ts));

    sc_trig_ctrl #(.OVR_W(OVR_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .en(en_r), .src_ext(ext_sel_r),
        .ext_in(ext_trig), .tick(tick), .ts(ts), .conv_done(conv_done),
        .conv_data(conv_data), .ovr_clr(ovr_clr), .conv_start(conv_start),
        .ovr_cnt(ovr_cnt), .cap_valid(cap_valid), .cap(cap));

    sc_cap_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(cap_valid), .wr_cap(cap),
        .last(last_r), .clr(buf_clr), .raddr(buf_raddr), .rdata(buf_rdata),
        .irq(irq), .drop(drop));
endmodule

// File: tb/sample_capture_tb.sv
module sample_capture_tb;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              ext_trig = 1'b0;
    logic              conv_start;
    logic              conv_done = 1'b0;
    logic [11:0]       conv_data = '0;
    logic [ADDR_W-1:0] buf_raddr = '0;
    logic [31:0]       buf_rdata;
    logic              irq;

    int n_chk = 0, n_fail = 0;
    int lat = 3, lat_cnt = 0;
    int n_st = 0, n_done = 0, done_at_irq = -1;
    bit irq_seen = 0;
    logic [15:0] tsm = '0;
    logic [15:0] st_ts [0:127];
    logic [11:0] d_exp [0:127];
    logic [11:0] dval = 12'h123;

    always #2.5 clk = ~clk;

    sample_capture #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .irq(irq));

    // Bench timestamp model: cleared in reset, +1 per edge.
    always @(posedge clk) tsm <= rst_n ? tsm + 16'd1 : 16'd0;

    // Monitor and converter model, all at the falling edge.
    always @(negedge clk) begin
        if (conv_start) begin
            if (n_st < 128) st_ts[n_st] = tsm - 16'd1;
            n_st++;
        end
        if (irq && !irq_seen) begin
            irq_seen = 1;
            done_at_irq = n_done;
        end
        if (conv_done) conv_done = 1'b0;
        if (conv_start) lat_cnt = lat;
        else if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                conv_done = 1'b1;
                conv_data = dval;
                if (n_done < 128) d_exp[n_done] = dval;
                n_done++;
                dval = dval + 12'd7;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic buf_read(input int i, output logic [31:0] d);
        @(negedge clk);
        buf_raddr = ADDR_W'(i);
        @(negedge clk);
        d = buf_rdata;
    endtask

    task automatic restart_counts();
        @(negedge clk);
        n_st = 0; n_done = 0; irq_seen = 0; done_at_irq = -1;
    endtask

    task automatic stop_and_clear();
        reg_write(2'd2, 32'd0);
        repeat (lat + 4) @(negedge clk);
        reg_write(2'd3, 32'd3);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 conv_start", {31'b0, conv_start}, 32'd0);
        reg_read(2'd3, v); chk("R1 status", v, 32'd0);
        reg_read(2'd0, v); chk("R1 period", v, 32'd1);

        // R5 R6 R8 R9: sweep every buffer length
        lat = 3;
        reg_write(2'd0, 32'd12);
        for (int n = 1; n <= DEPTH; n++) begin
            reg_write(2'd1, 32'(n - 1));
            restart_counts();
            reg_write(2'd2, 32'd1);
            while (n_done < n + 3) @(negedge clk);
            chk("R6 samples at irq", 32'(done_at_irq), 32'(n));
            reg_read(2'd3, v);
            chk("R8 drop and irq set", v, 32'h3);
            for (int i = 0; i < n; i++) begin
                buf_read(i, v);
                chk("R5 R8 stored word", v, {st_ts[i], 4'b0, d_exp[i]});
            end
            stop_and_clear();
            reg_read(2'd3, v);
            chk("R9 status cleared", v, 32'd0);
        end

        // R2 period sweep
        lat = 1;
        reg_write(2'd1, 32'(DEPTH - 1));
        for (int p = 3; p <= 10; p++) begin
            reg_write(2'd0, 32'(p));
            restart_counts();
            reg_write(2'd2, 32'd1);
            while (n_st < 5) @(negedge clk);
            for (int k = 0; k < 4; k++)
                chk("R2 interval", 32'(st_ts[k+1] - st_ts[k]), 32'(p));
            stop_and_clear();
        end

        // R3 period rewrite mid-interval
        reg_write(2'd0, 32'd20);
        restart_counts();
        reg_write(2'd2, 32'd1);
        while (n_st < 2) @(negedge clk);
        repeat (6) @(negedge clk);
        reg_write(2'd0, 32'd5);
        while (n_st < 6) @(negedge clk);
        chk("R3 old interval kept", 32'(st_ts[2] - st_ts[1]), 32'd20);
        chk("R3 new interval", 32'(st_ts[3] - st_ts[2]), 32'd5);
        chk("R3 new interval again", 32'(st_ts[4] - st_ts[3]), 32'd5);
        stop_and_clear();

        // R4 R7 external trigger and overruns
        lat = 40;
        reg_write(2'd0, 32'd3);
        restart_counts();
        reg_write(2'd2, 32'd3);
        repeat (10) @(negedge clk);
        chk("R4 timer ignored", 32'(n_st), 32'd0);
        ext_trig = 1'b1;
        @(negedge clk);
        chk("R4 start after edge", {31'b0, conv_start}, 32'd1);
        repeat (4) @(negedge clk);
        ext_trig = 1'b0;
        chk("R4 held level one start", 32'(n_st), 32'd1);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); ext_trig = 1'b1;
            @(negedge clk); ext_trig = 1'b0;
            @(negedge clk);
        end
        chk("R7 no start while busy", 32'(n_st), 32'd1);
        reg_read(2'd3, v);
        chk("R7 overrun count", v[15:8], 32'd3);
        while (n_done < 1) @(negedge clk);
        repeat (2) @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk);
        chk("R4 start after done", 32'(n_st), 32'd2);
        reg_write(2'd3, 32'd2);
        reg_read(2'd3, v);
        chk("R7 overrun cleared", v[15:8], 32'd0);
        stop_and_clear();
        summary();
    end
endmodule